// File: doc/BRIEF.md
# Floating-Point Issue Hazard Checker

This block sits at the issue point of an in-order pipeline that feeds three floating-point units with different latencies: a pipelined adder, a pipelined multiplier and a divider that accepts no new operation while one is running. Every hazard stall is decided here and nowhere later. Each cycle, decode presents one instruction: a unit code, a destination register and two source registers. The block answers with a ready flag, and when valid and ready meet it raises an issue strobe that carries the unit code and destination.

Three kinds of state are tracked. The first is a write-back reservation vector with one bit per future cycle, which serializes the single register write port. The second is a per-register countdown to the cycle in which each pending result is written. The third is an occupancy counter for the divider. An instruction issues only if its write-back slot is free, its sources are ready in time, its destination has no write still in flight, and its unit can accept it.

Top module: `fpiss_hazard_unit`

## Requirements
- R1: After reset the reservation vector `wb_resv` is all zero, and any legal instruction is accepted at once.
- R2: `iss_fire` is high exactly in cycles where `dec_valid` and `dec_ready` are both high, and `iss_unit` and `iss_dst` then equal `dec_unit` and `dec_dst`. Unit codes: 0 adder, 1 multiplier, 2 divider, 3 reserved.
- R3: An instruction issued in cycle t to a unit of latency L writes back in cycle t+L (adder ADD_LAT, multiplier MUL_LAT, divider DIV_LAT). Bit j of `wb_resv` is 1 exactly when a write-back is scheduled j cycles after the current cycle. A stalled instruction adds no reservation.
- R4: An instruction stalls when the write-back cycle it would need is already reserved. At most one write-back is ever scheduled per cycle.
- R5: An instruction stalls while either source register has a pending write whose countdown exceeds READY_AT. The countdown is 1 in the write-back cycle, so with READY_AT=1 a consumer may issue in the producer's write-back cycle but not before.
- R6: An instruction stalls while its destination register has a pending write, up to and including that write's write-back cycle.
- R7: A divide stalls while an earlier divide has not yet reached its write-back cycle. Adder and multiplier operations have no structural stall other than the write port.
- R8: Unit code 3 is never accepted: `dec_ready` stays low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_ready | output | 1 | Presented instruction has no hazard |
| dec_unit | input | 2 | Target unit code |
| dec_dst | input | REG_AW | Destination register |
| dec_src_a | input | REG_AW | First source register |
| dec_src_b | input | REG_AW | Second source register |
| iss_fire | output | 1 | Issue strobe |
| iss_unit | output | 2 | Unit select of the issuing instruction |
| iss_dst | output | REG_AW | Destination of the issuing instruction |
| wb_resv | output | max latency + 1 | Write-back reservation vector, bit j = j cycles ahead |

## Verification
The bench builds the block with REG_AW=3, ADD_LAT=2, MUL_LAT=3 and DIV_LAT=5. With these values the reservation vector is only six bits wide and eight registers collide often, so write-port conflicts, RAW and WAW stalls and divider overlap all arise within a few cycles of one another. A long pseudo-random stream then reaches them in many combinations. The expected ready flag and the reservation vector are recomputed every cycle from absolute write-back cycle numbers that the bench keeps, and no countdown is mirrored.

// File: rtl/fpiss_pkg.sv
package fpiss_pkg;

   typedef enum logic [1:0] {
      FU_ADD  = 2'd0,
      FU_MUL  = 2'd1,
      FU_DIV  = 2'd2,
      FU_RSVD = 2'd3
   } fu_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/fpiss_wb_resv.sv
module fpiss_wb_resv #(
   parameter int RESV_W = 26,
   parameter int CW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [CW-1:0]     lat,
   output logic              hit,
   output logic [RESV_W-1:0] resv
);

   logic [RESV_W-1:0] resv_q;
   logic [RESV_W-1:0] resv_d;

   generate
      for (genvar j = 0; j < RESV_W; j++) begin : g_bit
         if (j == RESV_W-1) begin : g_top
            assign resv_d[j] = fire && (lat == CW'(j+1));
         end else begin : g_mid
            assign resv_d[j] = resv_q[j+1] || (fire && (lat == CW'(j+1)));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) resv_q <= '0;
      else        resv_q <= resv_d;
   end

   assign hit  = resv_q[lat];
   assign resv = resv_q;

   // R4: the port never takes a second writer for one cycle
   a_r4_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !resv_q[lat]);

   // R3: an issue lands one position below its latency after the shift
   a_r3_lands: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> resv_q[$past(lat) - CW'(1)]);

   // R3: without an issue the vector only drains
   a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> (resv_q == ($past(resv_q) >> 1)));

endmodule

// File: rtl/fpiss_scoreboard.sv
module fpiss_scoreboard #(
   parameter int REG_AW   = 5,
   parameter int CW       = 5,
   parameter int READY_AT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [CW-1:0]     lat,
   input  logic [REG_AW-1:0] dst,
   input  logic [REG_AW-1:0] src_a,
   input  logic [REG_AW-1:0] src_b,
   output logic              raw_hit,
   output logic              waw_hit
);

   localparam int NREG = 1 << REG_AW;

   logic [CW-1:0] cnt [NREG];

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)                             cnt[r] <= '0;
            else if (fire && (dst == REG_AW'(r)))   cnt[r] <= lat;
            else if (cnt[r] != '0)                  cnt[r] <= cnt[r] - CW'(1);
         end
      end
   endgenerate

   always_comb begin
      raw_hit = (cnt[src_a] > CW'(READY_AT)) || (cnt[src_b] > CW'(READY_AT));
      waw_hit = (cnt[dst] != '0);
   end

   // R5: an issuing instruction never reads a late operand
   a_r5_src_ready: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (cnt[src_a] <= CW'(READY_AT)) && (cnt[src_b] <= CW'(READY_AT)));

   // R6: an issuing instruction finds its destination idle
   a_r6_dst_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (cnt[dst] == '0));

   // R6: the destination countdown starts at the unit latency
   a_r6_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt[$past(dst)] == $past(lat)));

endmodule

// File: rtl/fpiss_unit_busy.sv
module fpiss_unit_busy #(
   parameter int LAT       = 25,
   parameter int CW        = 5,
   parameter bit PIPELINED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   generate
      if (PIPELINED) begin : g_pipe
         assign busy = 1'b0;
      end else begin : g_iter
         logic [CW-1:0] left;

         always_ff @(posedge clk) begin
            if (!rst_n)            left <= '0;
            else if (start)        left <= CW'(LAT);
            else if (left != '0)   left <= left - CW'(1);
         end

         assign busy = (left > CW'(1));

         // R7: a new operation only starts once the previous one is at write-back
         a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> (left <= CW'(1)));

         // R7: occupancy covers the full latency
         a_r7_loaded: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> (left == CW'(LAT)));
      end
   endgenerate

endmodule

// File: rtl/fpiss_hazard_unit.sv
module fpiss_hazard_unit
   import fpiss_pkg::*;
#(
   parameter int REG_AW        = 5,
   parameter int ADD_LAT       = 4,
   parameter int MUL_LAT       = 7,
   parameter int DIV_LAT       = 25,
   parameter int READY_AT      = 1,
   parameter bit DIV_PIPELINED = 1'b0,
   localparam int RESV_W       = max3(ADD_LAT, MUL_LAT, DIV_LAT) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_valid,
   output logic              dec_ready,
   input  logic [1:0]        dec_unit,
   input  logic [REG_AW-1:0] dec_dst,
   input  logic [REG_AW-1:0] dec_src_a,
   input  logic [REG_AW-1:0] dec_src_b,
   output logic              iss_fire,
   output logic [1:0]        iss_unit,
   output logic [REG_AW-1:0] iss_dst,
   output logic [RESV_W-1:0] wb_resv
);

   localparam int CW = $clog2(RESV_W);

   generate
      if (ADD_LAT < 1 || MUL_LAT < 1 || DIV_LAT < 1) begin : g_bad_lat
         $error("fpiss_hazard_unit: every latency must be at least 1");
      end
      if (READY_AT < 0 || READY_AT >= RESV_W) begin : g_bad_ready
         $error("fpiss_hazard_unit: READY_AT out of range");
      end
      if (REG_AW < 1) begin : g_bad_aw
         $error("fpiss_hazard_unit: REG_AW must be at least 1");
      end
   endgenerate

   fu_e           unit;
   logic [CW-1:0] lat;
   logic          resv_hit;
   logic          raw_hit;
   logic          waw_hit;
   logic          div_busy;
   logic          div_start;
   logic          stall;

   assign unit = fu_e'(dec_unit);

   always_comb begin
      unique case (unit)
         FU_ADD:  lat = CW'(ADD_LAT);
         FU_MUL:  lat = CW'(MUL_LAT);
         FU_DIV:  lat = CW'(DIV_LAT);
         default: lat = CW'(1);
      endcase
   end

   always_comb begin
      stall = (unit == FU_RSVD) || resv_hit || raw_hit || waw_hit
           || ((unit == FU_DIV) && div_busy);
   end

   assign dec_ready = !stall;
   assign iss_fire  = dec_valid && dec_ready;
   assign iss_unit  = dec_unit;
   assign iss_dst   = dec_dst;
   assign div_start = iss_fire && (unit == FU_DIV);

   fpiss_wb_resv #(
      .RESV_W (RESV_W),
      .CW     (CW)
   ) u_resv (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (iss_fire),
      .lat   (lat),
      .hit   (resv_hit),
      .resv  (wb_resv)
   );

   fpiss_scoreboard #(
      .REG_AW   (REG_AW),
      .CW       (CW),
      .READY_AT (READY_AT)
   ) u_sb (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (iss_fire),
      .lat     (lat),
      .dst     (dec_dst),
      .src_a   (dec_src_a),
      .src_b   (dec_src_b),
      .raw_hit (raw_hit),
      .waw_hit (waw_hit)
   );

   fpiss_unit_busy #(
      .LAT       (DIV_LAT),
      .CW        (CW),
      .PIPELINED (DIV_PIPELINED)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .busy  (div_busy)
   );

   // R8: the reserved code never leaves the issue stage
   a_r8_rsvd_held: assert property (@(posedge clk) disable iff (!rst_n)
      iss_fire |-> (dec_unit != FU_RSVD));

   // R4: after an issue the reservation vector is never empty
   a_r4_resv_set: assert property (@(posedge clk) disable iff (!rst_n)
      iss_fire |=> (wb_resv != '0));

   // R1: reservations exist only after some issue
   a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wb_resv) == '0 && !$past(iss_fire)) |-> (wb_resv == '0));

endmodule

// File: tb/fpiss_hazard_unit_bench.sv
module fpiss_hazard_unit_bench;

   localparam int AW   = 3;
   localparam int LA   = 2;
   localparam int LM   = 3;
   localparam int LD   = 5;
   localparam int RDY  = 1;
   localparam int RW   = LD + 1;
   localparam int NREG = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dec_valid = 1'b0;
   logic          dec_ready;
   logic [1:0]    dec_unit = '0;
   logic [AW-1:0] dec_dst = '0;
   logic [AW-1:0] dec_src_a = '0;
   logic [AW-1:0] dec_src_b = '0;
   logic          iss_fire;
   logic [1:0]    iss_unit;
   logic [AW-1:0] iss_dst;
   logic [RW-1:0] wb_resv;

   always #5 clk = ~clk;

   fpiss_hazard_unit #(
      .REG_AW  (AW),
      .ADD_LAT (LA),
      .MUL_LAT (LM),
      .DIV_LAT (LD),
      .READY_AT(RDY)
   ) u_fpiss_hazard_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec_valid (dec_valid),
      .dec_ready (dec_ready),
      .dec_unit  (dec_unit),
      .dec_dst   (dec_dst),
      .dec_src_a (dec_src_a),
      .dec_src_b (dec_src_b),
      .iss_fire  (iss_fire),
      .iss_unit  (iss_unit),
      .iss_dst   (iss_dst),
      .wb_resv   (wb_resv)
   );

   int nchk  = 0;
   int nfail = 0;
   int t     = 0;
   bit done  = 0;
   bit wb_busy [0:16383];
   int rwb [NREG];
   int dwb = -1;
   logic [31:0] lf = 32'h1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, t, act, exp);
      end
   endtask

   function automatic int lat_of(input int u);
      return (u == 0) ? LA : (u == 1) ? LM : LD;
   endfunction

   task automatic step(input bit v, input int u, input int d, input int a,
                       input int b, output bit fired);
      string rsn;
      int    l;
      bit    er;
      int    ev;
      dec_valid = v; dec_unit = u[1:0]; dec_dst = d[AW-1:0];
      dec_src_a = a[AW-1:0]; dec_src_b = b[AW-1:0];
      #2;
      rsn = "";
      l = 1;
      if (u == 3) rsn = "R8";
      else begin
         l = lat_of(u);
         if (wb_busy[t+l])                                 rsn = "R4";
         else if (rwb[a] > t+RDY-1 || rwb[b] > t+RDY-1)    rsn = "R5";
         else if (rwb[d] >= t)                             rsn = "R6";
         else if (u == 2 && dwb > t)                       rsn = "R7";
      end
      er = (rsn == "");
      chk(dec_ready == er, er ? "R2" : rsn, int'(dec_ready), int'(er));
      chk(iss_fire == (v && er), "R2", int'(iss_fire), int'(v && er));
      if (v && er) chk(iss_unit == u[1:0] && iss_dst == d[AW-1:0], "R2",
                       int'(iss_unit), u);
      ev = 0;
      for (int j = 0; j < RW; j++) if (wb_busy[t+j]) ev |= (1 << j);
      chk(int'(wb_resv) == ev, "R3", int'(wb_resv), ev);
      fired = v && er;
      if (fired) begin
         wb_busy[t+l] = 1'b1;
         rwb[d] = t + l;
         if (u == 2) dwb = t + l;
      end
      @(posedge clk);
      t++;
      #1;
   endtask

   task automatic push(input int u, input int d, input int a, input int b);
      bit f;
      for (int k = 0; k < 60; k++) begin
         step(1'b1, u, d, a, b, f);
         if (f) break;
      end
   endtask

   task automatic idle(input int n);
      bit f;
      for (int k = 0; k < n; k++) step(1'b0, 0, 0, 0, 0, f);
   endtask

   initial begin : wdog
      #(10 * 200000);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog expired at cycle %0d", t);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      bit f;
      int cu, cd, ca, cb;
      bit cv;
      for (int r = 0; r < NREG; r++) rwb[r] = -1;
      for (int i = 0; i < 16384; i++) wb_busy[i] = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t = 0;
      dec_valid = 1'b1; dec_unit = 2'd0; dec_dst = 3'd1;
      #1;
      // R1: empty after reset, legal instruction accepted
      chk(wb_resv == '0, "R1", int'(wb_resv), 0);
      chk(dec_ready == 1'b1, "R1", int'(dec_ready), 1);
      dec_valid = 1'b0;
      #1;
      @(posedge clk); t++; #1;

      // R4: multiply then add targeting the same write-back cycle
      push(1, 1, 0, 0);
      push(0, 2, 0, 0);
      idle(4);
      // R5: dependent add waits for its producer
      push(0, 3, 0, 0);
      push(0, 4, 3, 3);
      idle(4);
      // R6: second writer of one register waits
      push(2, 5, 0, 0);
      push(0, 5, 1, 2);
      idle(4);
      // R7: back-to-back divides
      push(2, 6, 0, 0);
      push(2, 7, 0, 0);
      idle(6);
      // R8: reserved code on an empty pipeline
      step(1'b1, 3, 0, 0, 0, f);
      step(1'b1, 3, 1, 2, 3, f);
      idle(1);

      cv = 0; cu = 0; cd = 0; ca = 0; cb = 0; f = 1;
      for (int n = 0; n < 4000; n++) begin
         if (!cv || f || cu == 3) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cv = lf[0] | lf[1];
            cu = (lf[3:2] == 2'd3) ? (lf[4] ? 3 : 0) : int'(lf[3:2]);
            cd = int'(lf[7:5]);
            ca = int'(lf[10:8]);
            cb = int'(lf[13:11]);
         end
         step(cv, cu, cd, ca, cb, f);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule